// File: doc/BRIEF.md
# Multi-Format Signed Adder-Subtractor

This block adds or subtracts two signed integers of a parameterised width, where a two-bit format code states how both operands and the result are encoded: two's complement, one's complement or sign-magnitude. Each format has its own carry handling. Two's complement drops the carry that leaves the sign position. One's complement feeds that carry back into the least significant position. Sign-magnitude compares the two signs and then adds or subtracts the magnitudes. The block is purely combinational: the sum and its flags follow the inputs with no register in the path.

Besides the result, the block reports an overflow flag and a zero flag. The overflow flag follows the rule that belongs to the chosen format. The zero flag recognises both zero patterns in the formats that have two. When a control input is set, only the low bits of the second operand are used, and a small helper widens them to full width in a way that suits the format. The block has no states. Its structure is a format decoder, a widening stage, a per-format arithmetic core and a flag stage.

Top module: `signed_addsub`

## Requirements
- R1: With format code 00 (two's complement) and `sub_en`=0, `sum_o` equals the operands added modulo 2^WIDTH. The carry out of the sign position is discarded.
- R2: In two's complement, `ovf_o` is 1 exactly when the true result lies outside [-2^(WIDTH-1), 2^(WIDTH-1)-1]. This is the case when the carry into the sign bit differs from the carry out of it. Subtracting the most negative value from a non-negative value therefore reports overflow.
- R3: With format code 01 (one's complement, where negative x is stored as the bitwise inverse of |x|), a carry out of the sign position is added back into bit 0 and then dropped. Whenever `ovf_o`=0, the decoded `sum_o` equals the true result.
- R4: In one's complement, `ovf_o` is 1 exactly when the true result lies outside [-(2^(WIDTH-1)-1), 2^(WIDTH-1)-1].
- R5: With format code 10 (sign-magnitude: bit WIDTH-1 is the sign, 1 meaning negative, and the lower bits are the magnitude), equal effective signs add the magnitudes and keep the common sign. Differing signs subtract the smaller magnitude from the larger and take the sign of the larger.
- R6: In sign-magnitude, `ovf_o` is 1 exactly when the magnitude addition carries out of the magnitude field, which is when the true result lies outside [-(2^(WIDTH-1)-1), 2^(WIDTH-1)-1].
- R7: A sign-magnitude result of value zero is always given as all zeros, never as a negative zero.
- R8: `zero_o` is 1 exactly when `sum_o` decodes to zero in the chosen format. This includes the all-ones pattern in one's complement and the sign-only pattern (only bit WIDTH-1 set) in sign-magnitude.
- R9: Format code 11 behaves exactly like format code 00.
- R10: An operand pair whose effective signs differ never raises `ovf_o`.
- R11: With `sub_en`=1, the result is `op_a` plus the negated second operand. Negation is invert-and-add-one in two's complement, invert in one's complement, and sign-bit flip in sign-magnitude.
- R12: With `sext_en`=1, the second operand is taken from the low NARROW_W bits of `op_b` and widened. In two's and one's complement, bit NARROW_W-1 is copied into every new upper bit. In sign-magnitude, bit NARROW_W-1 moves to bit WIDTH-1 and the magnitude is zero-filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand; when `sext_en`=1 only its low NARROW_W bits are used |
| sub_en | input | 1 | 1 = subtract `op_b` from `op_a`, 0 = add |
| fmt_sel | input | 2 | 00 two's complement, 01 one's complement, 10 sign-magnitude, 11 treated as 00 |
| sext_en | input | 1 | 1 = widen the narrow second operand before use |
| sum_o | output | WIDTH | Result in the selected format |
| ovf_o | output | 1 | Result does not fit in the selected format |
| zero_o | output | 1 | Result is a zero pattern of the selected format |

## Verification
The bench drives every pair of 6-bit operands, for both add and subtract, under each of the four format codes and with narrow widening both off and on. It computes the expected value from the decoded integers. Pairs of mixed sign set apart the end-around and magnitude-subtract paths from the plain discarded-carry path. Pairs that sum to zero show whether each format produces and recognises its zero patterns. Extreme pairs, such as subtracting the most negative two's complement value or adding two full magnitudes, separate a correct overflow rule from one that only looks at the final carry.

// File: rtl/signed_addsub_pkg.sv
package signed_addsub_pkg;

    typedef enum logic [1:0] {
        FMT_TWOS = 2'b00,
        FMT_ONES = 2'b01,
        FMT_SMAG = 2'b10,
        FMT_RSVD = 2'b11
    } num_fmt_e;

    // Reserved code folds onto two's complement
    function automatic num_fmt_e fold_fmt(input logic [1:0] code);
        num_fmt_e f;
        f = num_fmt_e'(code);
        if (f == FMT_RSVD) f = FMT_TWOS;
        return f;
    endfunction

endpackage

// File: rtl/signed_addsub_widen.sv
module signed_addsub_widen #(
    parameter int IN_W  = 4,
    parameter int OUT_W = 8
) (
    input  logic [IN_W-1:0]  narrow_i,
    input  logic             smag_i,
    output logic [OUT_W-1:0] wide_o
);
    localparam int EXT_W = OUT_W - IN_W;

    always_comb begin
        if (smag_i)
            wide_o = {narrow_i[IN_W-1], {EXT_W{1'b0}}, narrow_i[IN_W-2:0]};
        else
            wide_o = {{EXT_W{narrow_i[IN_W-1]}}, narrow_i};
    end

    always_comb begin
        // R12
        copy_sign_chk: assert (smag_i ||
            (wide_o[OUT_W-1:IN_W-1] == '0) || (wide_o[OUT_W-1:IN_W-1] == '1));
    end

endmodule

// File: rtl/signed_addsub_core.sv
module signed_addsub_core
    import signed_addsub_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    input  num_fmt_e         fmt_i,
    output logic [WIDTH-1:0] res_o,
    output logic             ovf_o
);
    localparam int M = WIDTH - 1;

    logic [WIDTH-1:0] addend;
    logic [WIDTH:0]   raw_sum;
    logic             carry_into_sign;
    logic             eff_b_sign;
    logic [M-1:0]     mag_a, mag_b;
    logic [M:0]       mag_sum;
    logic [M-1:0]     mag_out;
    logic             sign_out;

    assign mag_a = a_i[M-1:0];
    assign mag_b = b_i[M-1:0];

    always_comb begin
        addend          = sub_i ? ~b_i : b_i;
        raw_sum         = '0;
        carry_into_sign = 1'b0;
        mag_sum         = '0;
        mag_out         = '0;
        sign_out        = 1'b0;
        eff_b_sign      = addend[M];
        res_o           = '0;
        ovf_o           = 1'b0;
        unique case (fmt_i)
            FMT_ONES: begin
                raw_sum = {1'b0, a_i} + {1'b0, addend};
                res_o   = raw_sum[M:0] + {{M{1'b0}}, raw_sum[WIDTH]};
                ovf_o   = (a_i[M] == addend[M]) && (res_o[M] != a_i[M]);
            end
            FMT_SMAG: begin
                eff_b_sign = b_i[M] ^ sub_i;
                if (a_i[M] == eff_b_sign) begin
                    mag_sum  = {1'b0, mag_a} + {1'b0, mag_b};
                    mag_out  = mag_sum[M-1:0];
                    sign_out = a_i[M];
                    ovf_o    = mag_sum[M];
                end else if (mag_a >= mag_b) begin
                    mag_out  = mag_a - mag_b;
                    sign_out = a_i[M];
                end else begin
                    mag_out  = mag_b - mag_a;
                    sign_out = eff_b_sign;
                end
                if (mag_out == '0 && !ovf_o) sign_out = 1'b0;
                res_o = {sign_out, mag_out};
            end
            default: begin
                raw_sum         = {1'b0, a_i} + {1'b0, addend} + {{WIDTH{1'b0}}, sub_i};
                res_o           = raw_sum[M:0];
                carry_into_sign = raw_sum[M] ^ a_i[M] ^ addend[M];
                ovf_o           = carry_into_sign ^ raw_sum[WIDTH];
            end
        endcase
    end

    always_comb begin
        // R10
        mixed_sign_no_ovf_chk: assert (!(a_i[M] != eff_b_sign) || !ovf_o);
        // R7
        smag_pos_zero_chk: assert (fmt_i != FMT_SMAG || ovf_o ||
                                   res_o != {1'b1, {M{1'b0}}});
    end

endmodule

// File: rtl/signed_addsub_flags.sv
module signed_addsub_flags
    import signed_addsub_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] res_i,
    input  num_fmt_e         fmt_i,
    output logic             zero_o
);
    localparam int M = WIDTH - 1;

    always_comb begin
        unique case (fmt_i)
            FMT_ONES: zero_o = (res_i == '0) || (res_i == '1);
            FMT_SMAG: zero_o = (res_i[M-1:0] == '0);
            default:  zero_o = (res_i == '0);
        endcase
    end

    always_comb begin
        // R8
        zero_pattern_chk: assert (!zero_o ||
            res_i[M-1:0] == '0 || res_i[M-1:0] == '1);
    end

endmodule

// File: rtl/signed_addsub.sv
module signed_addsub
    import signed_addsub_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter int NARROW_W = 4
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             sub_en,
    input  logic [1:0]       fmt_sel,
    input  logic             sext_en,
    output logic [WIDTH-1:0] sum_o,
    output logic             ovf_o,
    output logic             zero_o
);
    num_fmt_e         fmt;
    logic [WIDTH-1:0] b_wide;
    logic [WIDTH-1:0] b_used;

    assign fmt = fold_fmt(fmt_sel);

    signed_addsub_widen #(.IN_W(NARROW_W), .OUT_W(WIDTH)) u_widen (
        .narrow_i (op_b[NARROW_W-1:0]),
        .smag_i   (fmt == FMT_SMAG),
        .wide_o   (b_wide)
    );

    assign b_used = sext_en ? b_wide : op_b;

    signed_addsub_core #(.WIDTH(WIDTH)) u_core (
        .a_i   (op_a),
        .b_i   (b_used),
        .sub_i (sub_en),
        .fmt_i (fmt),
        .res_o (sum_o),
        .ovf_o (ovf_o)
    );

    signed_addsub_flags #(.WIDTH(WIDTH)) u_flags (
        .res_i  (sum_o),
        .fmt_i  (fmt),
        .zero_o (zero_o)
    );

    always_comb begin
        // R9
        rsvd_fold_chk: assert (fmt_sel != 2'b11 || fmt == FMT_TWOS);
    end

endmodule

// File: tb/signed_addsub_test.sv
module signed_addsub_test;
    localparam int W  = 6;
    localparam int NW = 3;

    logic         clk = 1'b0;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic         sub_en = 1'b0, sext_en = 1'b0;
    logic [1:0]   fmt_sel = 2'b00;
    logic [W-1:0] sum_o;
    logic         ovf_o, zero_o;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    signed_addsub #(.WIDTH(W), .NARROW_W(NW)) uut (
        .op_a(op_a), .op_b(op_b), .sub_en(sub_en), .fmt_sel(fmt_sel),
        .sext_en(sext_en), .sum_o(sum_o), .ovf_o(ovf_o), .zero_o(zero_o)
    );

    // Decode a w-bit pattern: fmt 1 one's complement, 2 sign-magnitude, else two's
    function automatic int decode(input int bits, input int w, input int f);
        int mask, msb;
        mask = (1 << w) - 1;
        msb  = (bits >> (w - 1)) & 1;
        if (msb == 0) return bits & mask;
        if (f == 1) return -((~bits) & mask);
        if (f == 2) return -(bits & (mask >> 1));
        return (bits & mask) - (1 << w);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s fmt=%0d sub=%0b sx=%0b a=%0d b=%0d actual=%0d expected=%0d",
                     tag, fmt_sel, sub_en, sext_en, op_a, op_b, act, exp);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // Idle inputs: zero plus zero
        @(posedge clk); #1;
        check(sum_o == '0, "R1", int'(sum_o), 0);
        check(zero_o && !ovf_o, "R8", int'(zero_o), 1);
        for (int f = 0; f < 4; f++) begin
            for (int sx = 0; sx < 2; sx++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int a = 0; a < 64; a++) begin
                        for (int b = 0; b < 64; b++) begin
                            int fd, av, bv, effb, tru, lim_lo, lim_hi, got;
                            bit exp_ovf, exp_zero;
                            string rtag, otag;
                            @(negedge clk);
                            op_a = W'(a); op_b = W'(b);
                            sub_en = s[0]; sext_en = sx[0]; fmt_sel = f[1:0];
                            @(posedge clk); #1;
                            fd     = (f == 3) ? 0 : f;
                            av     = decode(a, W, fd);
                            bv     = sx ? decode(b & 7, NW, fd) : decode(b, W, fd);
                            effb   = s ? -bv : bv;
                            tru    = av + effb;
                            lim_hi = (1 << (W - 1)) - 1;
                            lim_lo = (fd == 0) ? -(1 << (W - 1)) : -lim_hi;
                            exp_ovf = (tru > lim_hi) || (tru < lim_lo);
                            got    = decode(int'(sum_o), W, fd);
                            if (sx) rtag = "R12";
                            else if (f == 3) rtag = "R9";
                            else if (s) rtag = "R11";
                            else if (fd == 0) rtag = "R1";
                            else if (fd == 1) rtag = "R3";
                            else rtag = "R5";
                            if ((av > 0 && effb < 0) || (av < 0 && effb > 0)) otag = "R10";
                            else if (fd == 0) otag = "R2";
                            else if (fd == 1) otag = "R4";
                            else otag = "R6";
                            check(ovf_o == exp_ovf, otag, int'(ovf_o), int'(exp_ovf));
                            if (!exp_ovf) begin
                                check(got == tru, rtag, got, tru);
                                if (fd == 2 && tru == 0)
                                    check(sum_o == '0, "R7", int'(sum_o), 0);
                                exp_zero = (tru == 0);
                            end else begin
                                exp_zero = (got == 0);
                            end
                            check(zero_o == exp_zero, "R8", int'(zero_o), int'(exp_zero));
                        end
                    end
                end
            end
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule